// File: doc/BRIEF.md
# Cyclic Read-Mode Word Sequencer

This block schedules the continuous read-out of a contactless memory tag. After reset it waits a fixed start-up time, then repeats a loop of word slots. Each slot opens with a listen window, during which an outside pattern detector may ask for receive mode. The data part of the slot follows the window. At the start of each data part the block sends a one-cycle strobe and a word address to the serializer. Addresses climb from a first-read address to a last-read address, both taken from the low half of the stored control word, and then wrap back to the first.

All timing counts carrier ticks, not system clocks. A carrier tick is a one-cycle pulse per field period. An option input selects a bit time of 32 or 64 ticks. A request raised inside a listen window stops the loop and hands control to command handling. When the command-done pulse arrives, the loop restarts at once from the first-read address.

Top module: `rsq_top`

## Requirements
- R1: While reset is held, and after it, listenOpen, wordStart and cmdActive are 0. The first listen window opens after 33 bit times of carrier ticks: 2112 ticks when optFast=0, and 1056 ticks when optFast=1.
- R2: Every word slot begins with a listen window of 5 bit times (320 or 160 ticks), and listenOpen is 1 for the whole window.
- R3: wordStart is a one-cycle pulse in the cycle after the window's last tick. The data part then lasts 45 bit times, so a full slot is 50 bit times (3200 or 1600 ticks).
- R4: optFast=1 selects 32 ticks per bit and optFast=0 selects 64 ticks per bit.
- R5: The first-read address is ctrlRange[7:0] and the last-read address is ctrlRange[15:8]. Words are issued in ascending order and wrap to the first address after the last one. If the two addresses are equal, that one word repeats.
- R6: If first > last, or if either address is above 33, the range is invalid. The block then repeats one address: the first-read address, clamped to 33 at most.
- R7: When rmRequest is 1 during a listen window, cmdActive goes to 1 in the next cycle. While cmdActive is 1, no listen window opens and no wordStart pulse is issued.
- R8: rmRequest outside a listen window has no effect. The slot schedule and the address order go on unchanged.
- R9: When cmdDone is 1 while cmdActive is 1, a listen window opens in the next cycle with no start-up wait. The next word issued is the first-read address.
- R10: Only cycles with carrierTick=1 advance the timing. Without ticks, the phase holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| carrierTick | input | 1 | One-cycle pulse per carrier period |
| optFast | input | 1 | 1: 32 ticks per bit, 0: 64 ticks per bit |
| ctrlRange | input | 16 | Control word bits 15:0 (first-read in 7:0, last-read in 15:8) |
| rmRequest | input | 1 | Receive-mode request from the pattern detector |
| cmdDone | input | 1 | Pulse when command handling finishes |
| wordAddr | output | 8 | Address of the word being issued, valid with wordStart |
| wordStart | output | 1 | One-cycle strobe at the start of a word's data part |
| listenOpen | output | 1 | High during a listen window |
| cmdActive | output | 1 | High while command handling owns the tag |

## Verification
The assertions check, on every cycle, the rules that need only a short history. A strobe is always preceded by a listen window and never repeats on the next cycle. Command mode can only be entered from a window with a request, and it can only be left with a done pulse into a new window. A missing tick never closes a window. Issued addresses stay inside the programmed range, or equal the clamped fallback address. The tick counts of the start-up wait, the window and the data part, the wrap order over several slots, and the restart at the first address after a command cover thousands of cycles. Only the bench scenarios show these.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [1:0] {
    PH_INIT   = 2'd0,
    PH_LISTEN = 2'd1,
    PH_DATA   = 2'd2,
    PH_CMD    = 2'd3
  } phase_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic clrCount;   // zero the tick and bit counters
    logic loadFirst;  // load the first-read address
    logic stepAddr;   // advance to the next address (with wrap)
  } ctlStrb_t;

endpackage

// File: rtl/rsq_datapath.sv
module rsq_datapath
  import rsq_pkg::*;
#(
  parameter int SLOW_BIT    = 64,
  parameter int FAST_BIT    = 32,
  parameter int INIT_BITS   = 33,
  parameter int LISTEN_BITS = 5,
  parameter int DATA_BITS   = 45,
  parameter int ADDR_W      = 8,
  parameter int MAX_ADDR    = 33
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                carrierTick,
  input  logic                optFast,
  input  logic [2*ADDR_W-1:0] ctrlRange,
  input  phase_e              phase,
  input  ctlStrb_t            strb,
  output logic                phaseDone,
  output logic [ADDR_W-1:0]   wordAddr
);

  localparam int MAX_LD    = (INIT_BITS > LISTEN_BITS) ? INIT_BITS : LISTEN_BITS;
  localparam int MAX_PHASE = (DATA_BITS > MAX_LD) ? DATA_BITS : MAX_LD;
  localparam int TICK_W    = $clog2(SLOW_BIT);
  localparam int BIT_W     = $clog2(MAX_PHASE);

  logic [TICK_W-1:0] tickCnt, tickLast;
  logic [BIT_W-1:0]  bitCnt, phaseLast;
  logic              bitEnd;

  // Bit length chosen by the rate option (R4)
  always_comb tickLast = optFast ? TICK_W'(FAST_BIT - 1) : TICK_W'(SLOW_BIT - 1);

  // Phase length in bit times (R1, R2, R3)
  always_comb begin
    unique case (phase)
      PH_INIT:   phaseLast = BIT_W'(INIT_BITS - 1);
      PH_LISTEN: phaseLast = BIT_W'(LISTEN_BITS - 1);
      PH_DATA:   phaseLast = BIT_W'(DATA_BITS - 1);
      default:   phaseLast = '0;
    endcase
  end

  assign bitEnd    = carrierTick && (tickCnt == tickLast);
  assign phaseDone = bitEnd && (bitCnt == phaseLast) && (phase != PH_CMD);

  // Tick and bit counters advance only on carrier ticks (R10)
  always_ff @(posedge clk) begin
    if (!rstN || strb.clrCount) begin
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (carrierTick) begin
      if (bitEnd) begin
        tickCnt <= '0;
        bitCnt  <= phaseDone ? '0 : bitCnt + 1'b1;
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  // Address range decode (R5, R6)
  logic [ADDR_W-1:0] firstRaw, lastRaw, firstEff, lastEff, nextAddr, addrQ;
  logic              rangeOk;

  assign firstRaw = ctrlRange[ADDR_W-1:0];
  assign lastRaw  = ctrlRange[2*ADDR_W-1:ADDR_W];

  always_comb begin
    rangeOk  = (firstRaw <= lastRaw) && (lastRaw <= ADDR_W'(MAX_ADDR));
    firstEff = (firstRaw > ADDR_W'(MAX_ADDR)) ? ADDR_W'(MAX_ADDR) : firstRaw;
    lastEff  = rangeOk ? lastRaw : firstEff;
    if ((addrQ >= lastEff) || (addrQ < firstEff)) nextAddr = firstEff;
    else                                          nextAddr = addrQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               addrQ <= '0;
    else if (strb.loadFirst) addrQ <= firstEff;
    else if (strb.stepAddr)  addrQ <= nextAddr;
  end

  assign wordAddr = addrQ;

endmodule

// File: rtl/rsq_control.sv
module rsq_control
  import rsq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     phaseDone,
  input  logic     rmRequest,
  input  logic     cmdDone,
  output phase_e   phase,
  output ctlStrb_t strb,
  output logic     wordStart,
  output logic     listenOpen,
  output logic     cmdActive
);

  phase_e state, nextState;
  logic   startNext;

  always_comb begin
    nextState = state;
    strb      = '0;
    startNext = 1'b0;
    unique case (state)
      PH_INIT: begin
        if (phaseDone) begin
          nextState      = PH_LISTEN;
          strb.clrCount  = 1'b1;
          strb.loadFirst = 1'b1;
        end
      end
      PH_LISTEN: begin
        // A request inside the window wins over the window's end (R7)
        if (rmRequest) begin
          nextState     = PH_CMD;
          strb.clrCount = 1'b1;
        end else if (phaseDone) begin
          nextState = PH_DATA;
          startNext = 1'b1;
        end
      end
      PH_DATA: begin
        // Requests are not looked at here (R8)
        if (phaseDone) begin
          nextState     = PH_LISTEN;
          strb.stepAddr = 1'b1;
        end
      end
      default: begin
        strb.clrCount = 1'b1;
        if (cmdDone) begin
          nextState      = PH_LISTEN;
          strb.loadFirst = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= PH_INIT;
      wordStart <= 1'b0;
    end else begin
      state     <= nextState;
      wordStart <= startNext;
    end
  end

  assign phase      = state;
  assign listenOpen = (state == PH_LISTEN);
  assign cmdActive  = (state == PH_CMD);

endmodule

// File: rtl/rsq_top.sv
module rsq_top
  import rsq_pkg::*;
#(
  parameter int SLOW_BIT    = 64,
  parameter int FAST_BIT    = 32,
  parameter int INIT_BITS   = 33,
  parameter int LISTEN_BITS = 5,
  parameter int DATA_BITS   = 45,
  parameter int ADDR_W      = 8,
  parameter int MAX_ADDR    = 33
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                carrierTick,
  input  logic                optFast,
  input  logic [2*ADDR_W-1:0] ctrlRange,
  input  logic                rmRequest,
  input  logic                cmdDone,
  output logic [ADDR_W-1:0]   wordAddr,
  output logic                wordStart,
  output logic                listenOpen,
  output logic                cmdActive
);

  phase_e   phase;
  ctlStrb_t strb;
  logic     phaseDone;

  rsq_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .phaseDone  (phaseDone),
    .rmRequest  (rmRequest),
    .cmdDone    (cmdDone),
    .phase      (phase),
    .strb       (strb),
    .wordStart  (wordStart),
    .listenOpen (listenOpen),
    .cmdActive  (cmdActive)
  );

  rsq_datapath #(
    .SLOW_BIT    (SLOW_BIT),
    .FAST_BIT    (FAST_BIT),
    .INIT_BITS   (INIT_BITS),
    .LISTEN_BITS (LISTEN_BITS),
    .DATA_BITS   (DATA_BITS),
    .ADDR_W      (ADDR_W),
    .MAX_ADDR    (MAX_ADDR)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .carrierTick (carrierTick),
    .optFast     (optFast),
    .ctrlRange   (ctrlRange),
    .phase       (phase),
    .strb        (strb),
    .phaseDone   (phaseDone),
    .wordAddr    (wordAddr)
  );

endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
  parameter int ADDR_W   = 8,
  parameter int MAX_ADDR = 33
) (
  input logic                clk,
  input logic                rstN,
  input logic                carrierTick,
  input logic [2*ADDR_W-1:0] ctrlRange,
  input logic                rmRequest,
  input logic                cmdDone,
  input logic [ADDR_W-1:0]   wordAddr,
  input logic                wordStart,
  input logic                listenOpen,
  input logic                cmdActive
);

  logic [ADDR_W-1:0] chkFirst, chkLast, chkClamp;
  logic              chkValid;

  assign chkFirst = ctrlRange[ADDR_W-1:0];
  assign chkLast  = ctrlRange[2*ADDR_W-1:ADDR_W];
  assign chkValid = (chkFirst <= chkLast) && (chkLast <= ADDR_W'(MAX_ADDR));
  assign chkClamp = (chkFirst > ADDR_W'(MAX_ADDR)) ? ADDR_W'(MAX_ADDR) : chkFirst;

  assert_window_before_word_R2: assert property (@(posedge clk) disable iff (!rstN)
    wordStart |-> $past(listenOpen));

  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    wordStart |=> !wordStart);

  assert_addr_in_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wordStart && chkValid) |-> (wordAddr >= chkFirst && wordAddr <= chkLast));

  assert_fallback_addr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wordStart && !chkValid) |-> (wordAddr == chkClamp));

  assert_cmd_entry_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdActive) |-> $past(listenOpen && rmRequest));

  assert_cmd_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmdActive |-> (!listenOpen && !wordStart));

  assert_req_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!listenOpen && !cmdActive && rmRequest) |=> !cmdActive);

  assert_cmd_exit_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmdActive) |-> (listenOpen && $past(cmdDone)));

  assert_tick_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (listenOpen && !carrierTick && !rmRequest) |=> listenOpen);

endmodule

bind rsq_top rsq_checker #(.ADDR_W(ADDR_W), .MAX_ADDR(MAX_ADDR)) u_chk (.*);

// File: tb/tb_rsq_top.sv
module tb_rsq_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        carrierTick;
  logic        optFast = 1'b1;
  logic [15:0] ctrlRange = '0;
  logic        rmRequest = 1'b0;
  logic        cmdDone = 1'b0;
  logic [7:0]  wordAddr;
  logic        wordStart, listenOpen, cmdActive;

  always #2 clk = ~clk;

  logic tickAlt = 1'b0;
  logic tickToggle = 1'b0;
  always @(negedge clk) tickToggle <= ~tickToggle;
  assign carrierTick = tickAlt ? tickToggle : 1'b1;

  rsq_top dut (
    .clk(clk), .rstN(rstN), .carrierTick(carrierTick), .optFast(optFast),
    .ctrlRange(ctrlRange), .rmRequest(rmRequest), .cmdDone(cmdDone),
    .wordAddr(wordAddr), .wordStart(wordStart), .listenOpen(listenOpen),
    .cmdActive(cmdActive)
  );

  int checks = 0;
  int failures = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // sel 0: listenOpen, 1: wordStart, 2: cmdActive
  task automatic waitSig(input int sel, input int limit, output int n,
                         output bit found, output bit sawCmd);
    n = 0; found = 1'b0; sawCmd = 1'b0;
    while (!found && n < limit) begin
      @(posedge clk); #1;
      n++;
      if (cmdActive) sawCmd = 1'b1;
      case (sel)
        0:       found = listenOpen;
        1:       found = wordStart;
        default: found = cmdActive;
      endcase
    end
  endtask

  task automatic doReset(input logic [7:0] first, input logic [7:0] last, input logic fast);
    @(negedge clk);
    rstN = 1'b0; ctrlRange = {last, first}; optFast = fast;
    rmRequest = 1'b0; cmdDone = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Stimulus table: first, last, fast option, four expected addresses
  localparam int NV = 8;
  localparam int vFirst [NV] = '{2, 4, 30, 6, 40, 31, 5, 1};
  localparam int vLast  [NV] = '{5, 4, 33, 3, 50, 33, 40, 2};
  localparam int vOpt   [NV] = '{1, 1, 1, 1, 1, 1, 1, 0};
  localparam int vExp   [NV][4] = '{
    '{2, 3, 4, 5}, '{4, 4, 4, 4}, '{30, 31, 32, 33}, '{6, 6, 6, 6},
    '{33, 33, 33, 33}, '{31, 32, 33, 31}, '{5, 5, 5, 5}, '{1, 2, 1, 2}};

  initial begin
    #(4 * 190000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    bit found, sawCmd;

    // R1: outputs idle while reset is held
    @(negedge clk); @(negedge clk);
    check(!listenOpen && !wordStart && !cmdActive, "R1 reset idle", {listenOpen, wordStart, cmdActive}, 0);

    // Table walk: R5, R6 address order; R1, R3, R4 slot timing
    for (int v = 0; v < NV; v++) begin
      int slot, first0;
      slot   = vOpt[v] ? 1600 : 3200;
      first0 = vOpt[v] ? 1216 : 2432;
      doReset(8'(vFirst[v]), 8'(vLast[v]), vOpt[v] != 0);
      for (int k = 0; k < 4; k++) begin
        waitSig(1, 8000, n, found, sawCmd);
        check(found && wordAddr == 8'(vExp[v][k]), "R5/R6 address order", wordAddr, vExp[v][k]);
        if (k == 0) check(n == first0, "R1 start-up plus window", n, first0);
        else        check(n == slot, "R3/R4 slot length", n, slot);
      end
    end

    // R1, R2, R3 phase lengths, fast option
    doReset(8'd2, 8'd5, 1'b1);
    waitSig(0, 5000, n, found, sawCmd);
    check(found && n == 1056, "R1 start-up fast", n, 1056);
    waitSig(1, 5000, n, found, sawCmd);
    check(found && n == 160, "R2 window fast", n, 160);
    waitSig(0, 5000, n, found, sawCmd);
    check(found && n == 1440, "R3 data part fast", n, 1440);

    // R4 slow option
    doReset(8'd2, 8'd5, 1'b0);
    waitSig(0, 5000, n, found, sawCmd);
    check(found && n == 2112, "R4 start-up slow", n, 2112);
    waitSig(1, 5000, n, found, sawCmd);
    check(found && n == 320, "R4 window slow", n, 320);
    waitSig(0, 5000, n, found, sawCmd);
    check(found && n == 2880, "R4 data part slow", n, 2880);

    // R10: ticks on every other clock double the start-up in clocks
    tickAlt = 1'b1;
    doReset(8'd2, 8'd5, 1'b1);
    waitSig(0, 5000, n, found, sawCmd);
    check(found && (n == 2111 || n == 2112), "R10 ticks counted", n, 2112);
    tickAlt = 1'b0;

    // R8: request during the data part is ignored
    doReset(8'd2, 8'd5, 1'b1);
    waitSig(1, 5000, n, found, sawCmd);
    repeat (100) @(negedge clk);
    rmRequest = 1'b1;
    @(negedge clk);
    rmRequest = 1'b0;
    check(!cmdActive, "R8 no command entry", cmdActive, 0);
    waitSig(1, 5000, n, found, sawCmd);
    check(found && !sawCmd && wordAddr == 8'd3, "R8 schedule unchanged", wordAddr, 3);
    check(n == 1500, "R8 slot timing kept", n, 1500);

    // R7: request inside a window enters command mode
    waitSig(0, 5000, n, found, sawCmd);
    @(negedge clk);
    rmRequest = 1'b1;
    @(negedge clk);
    rmRequest = 1'b0;
    check(cmdActive && !listenOpen, "R7 command entry", cmdActive, 1);
    waitSig(1, 4000, n, found, sawCmd);
    check(!found && cmdActive, "R7 no words in command mode", found, 0);

    // R9: done pulse restarts at the first address without start-up wait
    @(negedge clk);
    cmdDone = 1'b1;
    @(negedge clk);
    cmdDone = 1'b0;
    check(listenOpen && !cmdActive, "R9 window reopens", listenOpen, 1);
    waitSig(1, 5000, n, found, sawCmd);
    check(found && n == 160, "R9 window length after command", n, 160);
    check(wordAddr == 8'd2, "R9 restart at first address", wordAddr, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule